// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block keeps track of the operating mode of a small microcontroller. There are five modes: active at full speed, active at medium speed, sleep at full speed, sleep at medium speed, and subactive, which runs on the watch clock. The CPU raises a one-cycle sleep strobe. The block then reads its latched control bits and either enters the matching sleep mode or flags the request as unsupported. Standby, watch and direct-transfer modes are not implemented, so a strobe that would select one of them is refused.

While the system sleeps, the CPU is held halted and the PWM clock is gated off. All other peripherals keep running. An enabled interrupt request wakes the system, provided the global mask is clear. Sleep at full speed returns to active at full speed, and sleep at medium speed returns to active at medium speed. The wake-up is marked by a one-cycle pulse so that the CPU can start exception handling. A synchronous reset also ends sleep.

The control bits are loaded through a small two-register write port. The block drives the medium-speed divider select straight out. It drives the subactive divider select as a normalised code, and this select cannot be changed while the system is in subactive mode. The system enters and leaves subactive when the external oscillator control reports that it is running from the watch clock.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, the outputs are as follows: `mode_o`=0, `cpu_halt_o`=0, `pwm_en_o`=1, `clk_med_o`=0, `med_div_o`=0, `sub_div_o`=0, `wake_o`=0 and `err_o`=0. All control bits are cleared.
- R2: The `mode_o` encoding is 0 active-high, 1 active-medium, 2 sleep-high, 3 sleep-medium and 4 subactive. A sleep strobe in an active mode, with standby, low-speed, medium-on and transfer bits all 0, gives `mode_o`=2 at the next edge, with `cpu_halt_o`=1 and `pwm_en_o`=0.
- R3: A sleep strobe in an active mode with medium-on=1 and standby, low-speed and transfer all 0 gives `mode_o`=3 and `clk_med_o`=1. `med_div_o` always shows register A bits [5:4].
- R4: If a sleep mode sees any request bit whose enable bit is also set, and the mask is 0, the next edge sets `mode_o` to 0 from mode 2 or to 1 from mode 3. `wake_o` is high for exactly that one cycle.
- R5: A sleep mode is held while the mask is 1 or no request has its enable bit set. The sleep strobe and the watch-clock input are ignored during sleep.
- R6: The reset input ends sleep and returns the block to active-high with the R1 values.
- R7: `sub_div_o` maps register A bits [1:0] as follows: 00 gives 0 (divide by 8), 01 gives 1 (divide by 4), and 10 or 11 give 2 (divide by 2). Code 3 never appears.
- R8: While `mode_o`=4, a write to register A leaves bits [1:0] unchanged, so `sub_div_o` holds. The other fields of register A are still written.
- R9: A sleep strobe in an active mode with standby (A bit 7), low-speed (A bit 6) or transfer (B bit 0) set leaves `mode_o` unchanged and pulses `err_o` for one cycle.
- R10: In an active mode, `watch_clk_i`=1 gives `mode_o`=4 at the next edge. This takes priority over the strobe. In mode 4, `watch_clk_i`=0 returns to the active speed given by medium-on. A strobe in mode 4 pulses `err_o`.
- R11: Outside sleep, the active speed follows the medium-on bit (register B bit 1): 1 gives mode 1 and 0 gives mode 0, one edge after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | One-cycle sleep strobe from the CPU |
| watch_clk_i | input | 1 | High when running from the watch clock |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 1 | Register select: 0 = register A, 1 = register B |
| wr_data_i | input | 8 | Register write data |
| irq_req_i | input | N_IRQ | Interrupt request lines |
| irq_en_i | input | N_IRQ | Per-source interrupt enables |
| irq_mask_i | input | 1 | Global interrupt mask |
| mode_o | output | 3 | Current mode code |
| cpu_halt_o | output | 1 | CPU halt |
| pwm_en_o | output | 1 | PWM clock enable |
| clk_med_o | output | 1 | Medium-speed clock in use |
| med_div_o | output | 2 | Medium-speed divider select |
| sub_div_o | output | 2 | Subactive divider code |
| wake_o | output | 1 | Wake pulse that starts interrupt handling |
| err_o | output | 1 | Unsupported-request pulse |

## Verification
The checker tests a set of properties on every cycle. These are: the sleep entries that follow a qualified strobe, the return to the matching active speed on a qualified interrupt, a sleep mode held still while masked, the divider code never reaching 3, the subactive lock, and the mode being unchanged whenever an error pulse appears. Other behaviour needs the bench's scenarios, each driven as a sequence of register writes, strobes and interrupts and compared against the reference model cycle by cycle. These include each field of the control registers landing in the right place, the error cases for each separate unsupported bit, a reset during sleep, and a write whose other fields take effect while its subactive select is refused.

// File: rtl/pwr_mode_pkg.sv
// Shared types for the low-power mode sequencer.
// Assumes an 8-bit register write port with two register slots.
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        MODE_ACT_HI  = 3'd0,
        MODE_ACT_MED = 3'd1,
        MODE_SLP_HI  = 3'd2,
        MODE_SLP_MED = 3'd3,
        MODE_SUBACT  = 3'd4
    } mode_e;

    typedef struct packed {
        logic       stby;
        logic       lspd;
        logic       med_on;
        logic       xfer;
        logic [1:0] med_sel;
        logic [1:0] sub_sel;
    } cfg_t;

    // Field positions in register A
    localparam int A_STBY_BIT = 7;
    localparam int A_LSPD_BIT = 6;
    localparam int A_MED_LSB  = 4;
    localparam int A_SUB_LSB  = 0;
    // Field positions in register B
    localparam int B_MEDON_BIT = 1;
    localparam int B_XFER_BIT  = 0;

    // Normalise the subactive select into a divider code
    function automatic logic [1:0] sub_code(input logic [1:0] sel);
        if (sel[1])
            return 2'd2;
        else if (sel[0])
            return 2'd1;
        else
            return 2'd0;
    endfunction

    function automatic logic is_sleep(input mode_e m);
        return (m == MODE_SLP_HI) || (m == MODE_SLP_MED);
    endfunction

endpackage

// File: rtl/pms_cfg_regs.sv
// Control register pair for the mode sequencer.
// Register A holds standby, low-speed, medium select and subactive select;
// register B holds medium-on and transfer. The subactive select is frozen
// while sub_lock_i is high. Assumes the writer supplies whole registers.
module pms_cfg_regs
    import pwr_mode_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              sub_lock_i,
    output cfg_t              cfg_o
);

    localparam int MED_MSB = A_MED_LSB + 1;
    localparam int SUB_MSB = A_SUB_LSB + 1;

    cfg_t cfg_q;

    logic unused_data_bits;
    assign unused_data_bits = ^wr_data_i;

    // Load the addressed register, honouring the subactive lock
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (wr_en_i) begin
            if (!wr_sel_i) begin
                cfg_q.stby    <= wr_data_i[A_STBY_BIT];
                cfg_q.lspd    <= wr_data_i[A_LSPD_BIT];
                cfg_q.med_sel <= wr_data_i[MED_MSB:A_MED_LSB];
                if (!sub_lock_i)
                    cfg_q.sub_sel <= wr_data_i[SUB_MSB:A_SUB_LSB];
            end else begin
                cfg_q.med_on <= wr_data_i[B_MEDON_BIT];
                cfg_q.xfer   <= wr_data_i[B_XFER_BIT];
            end
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/pms_wake_qual.sv
// Interrupt wake qualifier: any request whose enable bit is set, blocked
// entirely by the global mask. Purely combinational; the mode FSM samples
// the result on each clock edge.
module pms_wake_qual #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] req_i,
    input  logic [N_IRQ-1:0] en_i,
    input  logic             mask_i,
    output logic             wake_ok_o
);

    logic [N_IRQ-1:0] hit;

    // Per-source qualification
    for (genvar g = 0; g < N_IRQ; g++) begin : g_src
        assign hit[g] = req_i[g] & en_i[g];
    end

    // Merge sources and apply the global mask
    always_comb begin
        wake_ok_o = (|hit) & ~mask_i;
    end

endmodule

// File: rtl/pms_mode_fsm.sv
// Mode state machine. Reads the control bits latched before the current
// edge. A strobe that selects an unsupported mode is refused with an error
// pulse. Assumes the strobe is one cycle wide and ignores it during sleep.
module pms_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  sleep_i,
    input  logic  watch_clk_i,
    input  logic  wake_ok_i,
    input  logic  stby_i,
    input  logic  lspd_i,
    input  logic  xfer_i,
    input  logic  med_on_i,
    output mode_e mode_o,
    output logic  wake_o,
    output logic  err_o
);

    mode_e mode_q, mode_d;
    logic  wake_d, err_d;
    logic  unsupported;
    mode_e act_speed;

    assign unsupported = stby_i | lspd_i | xfer_i;
    assign act_speed   = med_on_i ? MODE_ACT_MED : MODE_ACT_HI;

    // Next-mode decision
    always_comb begin
        mode_d = mode_q;
        wake_d = 1'b0;
        err_d  = 1'b0;
        unique case (mode_q)
            MODE_ACT_HI, MODE_ACT_MED: begin
                if (watch_clk_i)
                    mode_d = MODE_SUBACT;
                else if (sleep_i) begin
                    if (unsupported)
                        err_d = 1'b1;
                    else
                        mode_d = med_on_i ? MODE_SLP_MED : MODE_SLP_HI;
                end else
                    mode_d = act_speed;
            end
            MODE_SLP_HI: begin
                if (wake_ok_i) begin
                    mode_d = MODE_ACT_HI;
                    wake_d = 1'b1;
                end
            end
            MODE_SLP_MED: begin
                if (wake_ok_i) begin
                    mode_d = MODE_ACT_MED;
                    wake_d = 1'b1;
                end
            end
            MODE_SUBACT: begin
                if (!watch_clk_i)
                    mode_d = act_speed;
                else if (sleep_i)
                    err_d = 1'b1;
            end
            default: mode_d = MODE_ACT_HI;
        endcase
    end

    // State and pulse registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q <= MODE_ACT_HI;
            wake_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            wake_o <= wake_d;
            err_o  <= err_d;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/pwr_mode_seq.sv
// Low-power mode sequencer top. Ties the control registers, the wake
// qualifier and the mode FSM together and decodes the mode into the halt,
// PWM gating and clock-select outputs. Assumes a single clock domain.
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sleep_i,
    input  logic              watch_clk_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [N_IRQ-1:0]  irq_req_i,
    input  logic [N_IRQ-1:0]  irq_en_i,
    input  logic              irq_mask_i,
    output logic [2:0]        mode_o,
    output logic              cpu_halt_o,
    output logic              pwm_en_o,
    output logic              clk_med_o,
    output logic [1:0]        med_div_o,
    output logic [1:0]        sub_div_o,
    output logic              wake_o,
    output logic              err_o
);

    cfg_t  cfg;
    mode_e mode;
    logic  wake_ok;
    logic  sub_lock;

    assign sub_lock = (mode == MODE_SUBACT);

    pms_cfg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .sub_lock_i (sub_lock),
        .cfg_o      (cfg)
    );

    pms_wake_qual #(.N_IRQ(N_IRQ)) u_wake (
        .req_i     (irq_req_i),
        .en_i      (irq_en_i),
        .mask_i    (irq_mask_i),
        .wake_ok_o (wake_ok)
    );

    pms_mode_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sleep_i     (sleep_i),
        .watch_clk_i (watch_clk_i),
        .wake_ok_i   (wake_ok),
        .stby_i      (cfg.stby),
        .lspd_i      (cfg.lspd),
        .xfer_i      (cfg.xfer),
        .med_on_i    (cfg.med_on),
        .mode_o      (mode),
        .wake_o      (wake_o),
        .err_o       (err_o)
    );

    // Decode the mode into control outputs
    always_comb begin
        mode_o     = mode;
        cpu_halt_o = is_sleep(mode);
        pwm_en_o   = !is_sleep(mode);
        clk_med_o  = (mode == MODE_ACT_MED) || (mode == MODE_SLP_MED);
        med_div_o  = cfg.med_sel;
        sub_div_o  = sub_code(cfg.sub_sel);
    end

endmodule

// File: rtl/pwr_mode_seq_chk.sv
// Property checker for the mode sequencer, bound to every instance of the
// top. Observes ports and the latched control bits only.
module pwr_mode_seq_chk
    import pwr_mode_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sleep_i,
    input logic             watch_clk_i,
    input logic [N_IRQ-1:0] irq_req_i,
    input logic [N_IRQ-1:0] irq_en_i,
    input logic             irq_mask_i,
    input cfg_t             cfg,
    input logic [2:0]       mode_o,
    input logic             cpu_halt_o,
    input logic             pwm_en_o,
    input logic             clk_med_o,
    input logic [1:0]       sub_div_o,
    input logic             wake_o,
    input logic             err_o
);

    logic irq_ok;
    logic in_sleep;
    logic in_active;
    assign irq_ok    = !irq_mask_i && ((irq_req_i & irq_en_i) != '0);
    assign in_sleep  = (mode_o == 3'd2) || (mode_o == 3'd3);
    assign in_active = (mode_o == 3'd0) || (mode_o == 3'd1);

    assert_reset_state_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (mode_o == 3'd0 && pwm_en_o && !cpu_halt_o));

    assert_enter_sleep_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_active && sleep_i && !watch_clk_i && !cfg.stby && !cfg.lspd && !cfg.xfer && !cfg.med_on)
        |=> (mode_o == 3'd2 && cpu_halt_o && !pwm_en_o));

    assert_enter_sleep_med_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_active && sleep_i && !watch_clk_i && !cfg.stby && !cfg.lspd && !cfg.xfer && cfg.med_on)
        |=> (mode_o == 3'd3 && clk_med_o));

    assert_wake_med_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd3 && irq_ok) |=> (mode_o == 3'd1 && wake_o));

    assert_wake_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd2 && irq_ok) |=> (mode_o == 3'd0 && wake_o));

    assert_masked_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_sleep && !irq_ok) |=> $stable(mode_o));

    assert_sub_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sub_div_o != 2'd3);

    assert_sub_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd4) |=> $stable(sub_div_o));

    assert_err_no_move_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> $stable(mode_o));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_i     (sleep_i),
    .watch_clk_i (watch_clk_i),
    .irq_req_i   (irq_req_i),
    .irq_en_i    (irq_en_i),
    .irq_mask_i  (irq_mask_i),
    .cfg         (cfg),
    .mode_o      (mode_o),
    .cpu_halt_o  (cpu_halt_o),
    .pwm_en_o    (pwm_en_o),
    .clk_med_o   (clk_med_o),
    .sub_div_o   (sub_div_o),
    .wake_o      (wake_o),
    .err_o       (err_o)
);

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;

    localparam int N_IRQ = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep = 1'b0;
    logic             watch = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_sel = 1'b0;
    logic [7:0]       wr_data = '0;
    logic [N_IRQ-1:0] irq_req = '0;
    logic [N_IRQ-1:0] irq_en = '0;
    logic             irq_mask = 1'b0;

    logic [2:0] mode;
    logic       halt, pwm_en, clk_med, wake, err;
    logic [1:0] med_div, sub_div;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwr_mode_seq #(.N_IRQ(N_IRQ), .DATA_W(8)) i_pwr_mode_seq (
        .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .watch_clk_i(watch),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .irq_req_i(irq_req), .irq_en_i(irq_en), .irq_mask_i(irq_mask),
        .mode_o(mode), .cpu_halt_o(halt), .pwm_en_o(pwm_en), .clk_med_o(clk_med),
        .med_div_o(med_div), .sub_div_o(sub_div), .wake_o(wake), .err_o(err)
    );

    // Behavioural reference model
    int m_mode = 0;
    int m_msel = 0;
    int m_ssel = 0;
    bit m_stby = 0, m_lspd = 0, m_medon = 0, m_xfer = 0;
    bit m_wake = 0, m_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_msel = 0; m_ssel = 0;
            m_stby = 0; m_lspd = 0; m_medon = 0; m_xfer = 0;
            m_wake = 0; m_err = 0;
        end else begin
            int  nxt;
            bit  got_irq;
            nxt = m_mode;
            got_irq = !irq_mask && ((irq_req & irq_en) != 0);
            m_wake = 0;
            m_err = 0;
            if (m_mode <= 1) begin
                if (watch) nxt = 4;
                else if (sleep && (m_stby || m_lspd || m_xfer)) m_err = 1;
                else if (sleep) nxt = m_medon ? 3 : 2;
                else nxt = m_medon ? 1 : 0;
            end else if (m_mode == 4) begin
                if (!watch) nxt = m_medon ? 1 : 0;
                else if (sleep) m_err = 1;
            end else if (got_irq) begin
                nxt = m_mode - 2;
                m_wake = 1;
            end
            if (wr_en && !wr_sel) begin
                m_stby = wr_data[7];
                m_lspd = wr_data[6];
                m_msel = wr_data[5:4];
                if (m_mode != 4) m_ssel = wr_data[1:0];
            end else if (wr_en) begin
                m_medon = wr_data[1];
                m_xfer = wr_data[0];
            end
            m_mode = nxt;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_sub;
            bit bad;
            exp_sub = (m_ssel >= 2) ? 2 : m_ssel;
            bad = 0;
            checks++;
            if (mode != 3'(m_mode)) begin bad = 1; $display("FAIL R2 mode %0d exp %0d", mode, m_mode); end
            if (halt != (m_mode == 2 || m_mode == 3)) begin bad = 1; $display("FAIL R2 halt %0b", halt); end
            if (pwm_en != !(m_mode == 2 || m_mode == 3)) begin bad = 1; $display("FAIL R2 pwm_en %0b", pwm_en); end
            if (clk_med != (m_mode == 1 || m_mode == 3)) begin bad = 1; $display("FAIL R3 clk_med %0b", clk_med); end
            if (med_div != 2'(m_msel)) begin bad = 1; $display("FAIL R3 med_div %0d exp %0d", med_div, m_msel); end
            if (sub_div != 2'(exp_sub)) begin bad = 1; $display("FAIL R7 sub_div %0d exp %0d", sub_div, exp_sub); end
            if (wake != m_wake) begin bad = 1; $display("FAIL R4 wake %0b exp %0b", wake, m_wake); end
            if (err != m_err) begin bad = 1; $display("FAIL R9 err %0b exp %0b", err, m_err); end
            if (bad) fails++;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic strobe();
        sleep = 1;
        tick();
        sleep = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        // R1 reset state
        check(mode, 0, "R1 mode");
        check(pwm_en, 1, "R1 pwm_en");
        check(halt, 0, "R1 halt");
        check(sub_div, 0, "R1 sub_div");
        check(err, 0, "R1 err");

        // R2 sleep high entry
        strobe();
        check(mode, 2, "R2 mode");
        check(halt, 1, "R2 halt");
        check(pwm_en, 0, "R2 pwm_en");
        // R5 held with no request, with request but disabled, with mask
        sleep = 1; watch = 1; tick(); sleep = 0; watch = 0;
        check(mode, 2, "R5 strobe ignored");
        irq_req = 8'h04; tick(2);
        check(mode, 2, "R5 disabled source");
        irq_en = 8'h04; irq_mask = 1; tick(2);
        check(mode, 2, "R5 masked");
        // R4 wake to active high
        irq_mask = 0; tick();
        irq_req = 0;
        check(mode, 0, "R4 wake hi");
        check(wake, 1, "R4 pulse");
        tick();
        check(wake, 0, "R4 pulse width");

        // R11 and R3 medium speed
        wr(0, 8'h20);
        wr(1, 8'h02);
        tick();
        check(mode, 1, "R11 active med");
        check(med_div, 2, "R3 med_div");
        strobe();
        check(mode, 3, "R3 sleep med");
        check(clk_med, 1, "R3 clk_med");
        irq_req = 8'h80; irq_en = 8'h80; tick();
        irq_req = 0;
        check(mode, 1, "R4 wake med");

        // R9 unsupported combinations
        wr(0, 8'h80); strobe();
        check(err, 1, "R9 standby err");
        check(mode, 1, "R9 standby mode");
        wr(0, 8'h40); strobe();
        check(err, 1, "R9 lowspeed err");
        wr(0, 8'h00); wr(1, 8'h03); strobe();
        check(err, 1, "R9 transfer err");
        check(mode, 1, "R9 transfer mode");
        wr(1, 8'h00); tick();
        check(mode, 0, "R11 back to high");

        // R6 reset ends sleep
        wr(0, 8'h30); strobe();
        check(mode, 2, "R6 asleep");
        rst_n = 0; tick(); rst_n = 1; tick();
        check(mode, 0, "R6 mode");
        check(med_div, 0, "R6 regs cleared");

        // R7 subactive divider mapping
        wr(0, 8'h01); check(sub_div, 1, "R7 sel 01");
        wr(0, 8'h02); check(sub_div, 2, "R7 sel 10");
        wr(0, 8'h03); check(sub_div, 2, "R7 sel 11");
        wr(0, 8'h00); check(sub_div, 0, "R7 sel 00");

        // R10 and R8 subactive lock
        wr(0, 8'h01);
        watch = 1; tick();
        check(mode, 4, "R10 enter sub");
        wr(0, 8'h33);
        check(sub_div, 1, "R8 locked");
        check(med_div, 3, "R8 other fields written");
        strobe();
        check(err, 1, "R10 strobe in sub");
        watch = 0; tick();
        check(mode, 0, "R10 leave sub");
        wr(0, 8'h03);
        check(sub_div, 2, "R8 unlocked");

        // Mixed traffic, compared every cycle by the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom;
            sleep    = (r[2:0] == 3'd0);
            if (r[9:4] == 6'd0) watch = ~watch;
            wr_en    = (r[12:10] == 3'd0);
            wr_sel   = r[13];
            wr_data  = r[21:14] & 8'hF7;
            irq_req  = (r[24:22] == 3'd0) ? 8'(r[31:24]) : 8'h00;
            irq_en   = 8'hF0;
            irq_mask = r[3] & r[1];
            tick();
        end
        sleep = 0; wr_en = 0; watch = 0; irq_req = 0;
        tick(3);
        finish_run();
    end

endmodule